// File: doc/BRIEF.md
# Four-Level Address Translation Walker

This block turns a 64-bit linear address into a physical address. It walks a chain of four translation tables held in memory. Each table is 4 KiB and holds 512 entries of 8 bytes. A requester presents an address together with its privilege level and a write flag. The walker then either returns the physical address or returns a fault code and the level at which the walk stopped. The first table's base comes from a root-pointer input.

Table entries are fetched through a plain read port, and only one read is outstanding at a time. At each level the walker adds the level's 9-bit index, times 8, to the current table base. It issues one read and waits for the data. It checks the present bit and the access rights. It then takes entry bits 51:12 as the next table base, or as the final page frame. The low 12 address bits pass through as the page offset.

Before any read, an address that is not in canonical sign-extended form is rejected. When translation is switched off, the address is returned unchanged.

Top module: `ptw_top`

## Requirements
- R1: With `pg_en_i` low, an accepted request yields `rsp_valid_o` in the cycle after acceptance. The response carries `rsp_paddr_o` equal to the request address and `rsp_fault_o` = 0, and no memory read is issued.
- R2: With translation on, an address whose bits 63:47 are not all equal gets `rsp_fault_o` = 1 (non-canonical) and `rsp_level_o` = 0, with no memory read. A sign-extended upper-half address is accepted and walked.
- R3: A walk in which every entry permits the access issues exactly four reads. It returns `rsp_fault_o` = 0 and a physical address equal to {final entry bits 51:12, request bits 11:0}, with all other bits zero.
- R4: The read addresses are, in order: root + 8×bits[47:39], then B3 + 8×bits[38:30], then B2 + 8×bits[29:21], then B1 + 8×bits[20:12]. Each B is the previous entry's bits 51:12 shifted left by 12. Entry bits 63:52 and 11:3 are ignored.
- R5: An entry with bit 0 (present) clear ends the walk with `rsp_fault_o` = 2. `rsp_level_o` is set to that level (4 for the top table, 1 for the last), and no further read is issued.
- R6: A write request meeting an entry with bit 1 (writable) clear ends with `rsp_fault_o` = 3 at that level. A read is not affected by bit 1.
- R7: A request with privilege level 3 (user) meeting an entry with bit 2 (user-allowed) clear ends with `rsp_fault_o` = 3 at that level. Privilege levels 0 to 2 are not affected by bit 2.
- R8: When an entry is both not present and lacking permission, the not-present fault (code 2) is reported.
- R9: After reset, `req_ready_o` = 1, `rsp_valid_o` = 0 and `mem_req_o` = 0. `rsp_valid_o` is a one-cycle pulse, followed by `req_ready_o` high.
- R10: `mem_req_o` is a one-cycle pulse, and the next read is not issued before `mem_rvalid_i` returns the previous one. The walk is correct for any read latency of one cycle or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pg_en_i | input | 1 | Translation enable |
| root_base_i | input | 64 | Base address of the top-level table |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle, request accepted this cycle |
| req_vaddr_i | input | 64 | Linear address |
| req_cpl_i | input | 2 | Privilege level, 3 = user |
| req_write_i | input | 1 | Access is a write |
| rsp_valid_o | output | 1 | Response valid (one cycle) |
| rsp_paddr_o | output | 64 | Physical address, zero on fault |
| rsp_fault_o | output | 2 | 0 none, 1 non-canonical, 2 not present, 3 protection |
| rsp_level_o | output | 3 | Level at which a fault occurred, 0 otherwise |
| mem_req_o | output | 1 | Entry read request pulse |
| mem_addr_o | output | 64 | Entry byte address |
| mem_rvalid_i | input | 1 | Entry read data valid |
| mem_rdata_i | input | 64 | Entry read data |

## Verification
The hardest case to reach is a fault that appears only at a deep level after the upper levels have passed. Examples are a user-disallowed entry at level 2, or a missing entry at level 1. These cases also need the read log to stop at exactly the right count. The bench builds a private chain of tables for each test address, with chosen permission flags per level and noise in the ignored entry bits. It replays requests against a memory model whose read latency changes between tests. Its own walk of the same table image gives the expected address sequence, result and fault level.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RESP  = 2'd3
    } ptw_state_e;

    typedef enum logic [1:0] {
        FC_NONE     = 2'd0,
        FC_NONCANON = 2'd1,
        FC_NOTPRES  = 2'd2,
        FC_PROT     = 2'd3
    } ptw_fault_e;

    localparam int unsigned PTE_P_BIT  = 0;
    localparam int unsigned PTE_RW_BIT = 1;
    localparam int unsigned PTE_US_BIT = 2;
    localparam logic [1:0]  USER_CPL   = 2'd3;

endpackage

// File: rtl/ptw_addr_split.sv
module ptw_addr_split #(
    parameter int VA_W   = 64,
    parameter int SIG_W  = 48,
    parameter int OFF_W  = 12,
    parameter int IDX_W  = 9,
    parameter int LEVELS = 4,
    parameter int LVL_W  = 3
) (
    input  logic [VA_W-1:0]  vaddr_i,
    input  logic [LVL_W-1:0] level_i,
    output logic             canonical_o,
    output logic [IDX_W-1:0] index_o,
    output logic [OFF_W-1:0] offset_o
);
    localparam int EXT_W = VA_W - SIG_W + 1;

    logic [IDX_W-1:0] field [LEVELS];
    logic [EXT_W-1:0] ext;

    genvar g;
    generate
        for (g = 0; g < LEVELS; g++) begin : g_field
            assign field[g] = vaddr_i[OFF_W + g*IDX_W +: IDX_W];
        end
    endgenerate

    assign ext         = vaddr_i[VA_W-1:SIG_W-1];
    assign canonical_o = (&ext) | ~(|ext);
    assign offset_o    = vaddr_i[OFF_W-1:0];

    always_comb begin
        index_o = '0;
        for (int l = 1; l <= LEVELS; l++) begin
            if (level_i == LVL_W'(l)) index_o = field[l-1];
        end
    end

endmodule

// File: rtl/ptw_entry_check.sv
module ptw_entry_check
    import ptw_pkg::*;
#(
    parameter int PTE_W  = 64,
    parameter int PA_W   = 64,
    parameter int PA_TOP = 51,
    parameter int OFF_W  = 12
) (
    input  logic [PTE_W-1:0] pte_i,
    input  logic             write_i,
    input  logic             user_i,
    output logic             present_o,
    output logic             perm_ok_o,
    output logic [PA_W-1:0]  base_o
);
    localparam int FRAME_W = PA_TOP - OFF_W + 1;
    localparam int PAD_W   = PA_W - FRAME_W - OFF_W;

    logic unused_pte_bits;
    assign unused_pte_bits = ^{pte_i[PTE_W-1:PA_TOP+1], pte_i[OFF_W-1:PTE_US_BIT+1]};

    assign present_o = pte_i[PTE_P_BIT];
    assign perm_ok_o = !(write_i && !pte_i[PTE_RW_BIT]) && !(user_i && !pte_i[PTE_US_BIT]);
    assign base_o    = {{PAD_W{1'b0}}, pte_i[PA_TOP:OFF_W], {OFF_W{1'b0}}};

endmodule

// File: rtl/ptw_top.sv
module ptw_top
    import ptw_pkg::*;
#(
    parameter int VA_W   = 64,
    parameter int PA_W   = 64,
    parameter int PTE_W  = 64,
    parameter int SIG_W  = 48,
    parameter int OFF_W  = 12,
    parameter int IDX_W  = 9,
    parameter int LEVELS = 4,
    parameter int PA_TOP = 51,
    localparam int LVL_W = $clog2(LEVELS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pg_en_i,
    input  logic [PA_W-1:0]  root_base_i,
    input  logic             req_valid_i,
    output logic             req_ready_o,
    input  logic [VA_W-1:0]  req_vaddr_i,
    input  logic [1:0]       req_cpl_i,
    input  logic             req_write_i,
    output logic             rsp_valid_o,
    output logic [PA_W-1:0]  rsp_paddr_o,
    output logic [1:0]       rsp_fault_o,
    output logic [LVL_W-1:0] rsp_level_o,
    output logic             mem_req_o,
    output logic [PA_W-1:0]  mem_addr_o,
    input  logic             mem_rvalid_i,
    input  logic [PTE_W-1:0] mem_rdata_i
);
    localparam int ENT_SH = $clog2(PTE_W / 8);

    typedef struct packed {
        ptw_state_e       state;
        logic [LVL_W-1:0] level;
        logic [PA_W-1:0]  base;
        logic [VA_W-1:0]  vaddr;
        logic             write;
        logic             user;
        logic [PA_W-1:0]  paddr;
        ptw_fault_e       fault;
        logic [LVL_W-1:0] flevel;
    } walk_t;

    localparam walk_t WALK_RST = '{
        state:  ST_IDLE,
        level:  '0,
        base:   '0,
        vaddr:  '0,
        write:  1'b0,
        user:   1'b0,
        paddr:  '0,
        fault:  FC_NONE,
        flevel: '0
    };

    walk_t walk_d, walk_q;

    logic [VA_W-1:0]  split_va;
    logic             canonical;
    logic [IDX_W-1:0] index;
    logic [OFF_W-1:0] offset;
    logic             present;
    logic             perm_ok;
    logic [PA_W-1:0]  next_base;

    assign split_va = (walk_q.state == ST_IDLE) ? req_vaddr_i : walk_q.vaddr;

    ptw_addr_split #(
        .VA_W(VA_W), .SIG_W(SIG_W), .OFF_W(OFF_W),
        .IDX_W(IDX_W), .LEVELS(LEVELS), .LVL_W(LVL_W)
    ) u_split (
        .vaddr_i     (split_va),
        .level_i     (walk_q.level),
        .canonical_o (canonical),
        .index_o     (index),
        .offset_o    (offset)
    );

    ptw_entry_check #(
        .PTE_W(PTE_W), .PA_W(PA_W), .PA_TOP(PA_TOP), .OFF_W(OFF_W)
    ) u_entry (
        .pte_i     (mem_rdata_i),
        .write_i   (walk_q.write),
        .user_i    (walk_q.user),
        .present_o (present),
        .perm_ok_o (perm_ok),
        .base_o    (next_base)
    );

    always_comb begin
        walk_d = walk_q;
        unique case (walk_q.state)
            ST_IDLE: begin
                if (req_valid_i) begin
                    walk_d.vaddr  = req_vaddr_i;
                    walk_d.write  = req_write_i;
                    walk_d.user   = (req_cpl_i == USER_CPL);
                    walk_d.paddr  = '0;
                    walk_d.fault  = FC_NONE;
                    walk_d.flevel = '0;
                    if (!pg_en_i) begin
                        walk_d.paddr = PA_W'(req_vaddr_i);
                        walk_d.state = ST_RESP;
                    end else if (!canonical) begin
                        walk_d.fault = FC_NONCANON;
                        walk_d.state = ST_RESP;
                    end else begin
                        walk_d.base  = root_base_i;
                        walk_d.level = LVL_W'(LEVELS);
                        walk_d.state = ST_ISSUE;
                    end
                end
            end
            ST_ISSUE: walk_d.state = ST_WAIT;
            ST_WAIT: begin
                if (mem_rvalid_i) begin
                    if (!present) begin
                        walk_d.fault  = FC_NOTPRES;
                        walk_d.flevel = walk_q.level;
                        walk_d.state  = ST_RESP;
                    end else if (!perm_ok) begin
                        walk_d.fault  = FC_PROT;
                        walk_d.flevel = walk_q.level;
                        walk_d.state  = ST_RESP;
                    end else if (walk_q.level == LVL_W'(1)) begin
                        walk_d.paddr = next_base | PA_W'(offset);
                        walk_d.state = ST_RESP;
                    end else begin
                        walk_d.base  = next_base;
                        walk_d.level = walk_q.level - LVL_W'(1);
                        walk_d.state = ST_ISSUE;
                    end
                end
            end
            ST_RESP: walk_d.state = ST_IDLE;
            default: walk_d = WALK_RST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) walk_q <= WALK_RST;
        else        walk_q <= walk_d;
    end

    assign req_ready_o = (walk_q.state == ST_IDLE);
    assign rsp_valid_o = (walk_q.state == ST_RESP);
    assign rsp_paddr_o = walk_q.paddr;
    assign rsp_fault_o = walk_q.fault;
    assign rsp_level_o = walk_q.flevel;
    assign mem_req_o   = (walk_q.state == ST_ISSUE);
    assign mem_addr_o  = walk_q.base + (PA_W'(index) << ENT_SH);

    // R1
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o && !pg_en_i) |=>
        (rsp_valid_o && rsp_paddr_o == $past(req_vaddr_i) && rsp_fault_o == FC_NONE));

    // R2
    noncanon_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o && pg_en_i &&
         req_vaddr_i[VA_W-1:SIG_W-1] != '0 && req_vaddr_i[VA_W-1:SIG_W-1] != '1) |=>
        (rsp_valid_o && rsp_fault_o == FC_NONCANON && rsp_level_o == '0 && !mem_req_o));

    // R10
    read_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |=> !mem_req_o);

    // R5
    np_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && rsp_fault_o == FC_NOTPRES) |->
        (rsp_level_o >= LVL_W'(1) && rsp_level_o <= LVL_W'(LEVELS)));

    // R9
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |=> (!rsp_valid_o && req_ready_o));

endmodule

// File: tb/ptw_top_tb.sv
module ptw_top_tb;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [63:0] paddr;
        logic [1:0]  fault;
        logic [2:0]  lvl;
        int          nrd;
        logic [63:0] adr [4];
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pg_en = 1'b0;
    logic [63:0] root_base = 64'h0000_0000_0010_0000;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_vaddr = '0;
    logic [1:0]  req_cpl = '0;
    logic        req_write = 1'b0;
    logic        rsp_valid;
    logic [63:0] rsp_paddr;
    logic [1:0]  rsp_fault;
    logic [2:0]  rsp_level;
    logic        mem_req;
    logic [63:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [63:0] mem_rdata = '0;

    logic [63:0] mem [logic [63:0]];
    logic [63:0] rd_log [$];
    exp_t        sb_q [$];
    int          mem_lat = 1;
    logic [63:0] next_tbl = 64'h0000_0000_0020_0000;
    int          checks = 0;
    int          fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptw_top u_dut (
        .clk(clk), .rst_n(rst_n), .pg_en_i(pg_en), .root_base_i(root_base),
        .req_valid_i(req_valid), .req_ready_o(req_ready), .req_vaddr_i(req_vaddr),
        .req_cpl_i(req_cpl), .req_write_i(req_write), .rsp_valid_o(rsp_valid),
        .rsp_paddr_o(rsp_paddr), .rsp_fault_o(rsp_fault), .rsp_level_o(rsp_level),
        .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid),
        .mem_rdata_i(mem_rdata)
    );

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", what, act, exp);
        end
    endtask

    function automatic logic [63:0] rd_mem(input logic [63:0] a);
        return mem.exists(a) ? mem[a] : 64'h0;
    endfunction

    function automatic exp_t model(input logic [63:0] va, input logic [1:0] cpl,
                                   input logic wr, input logic pg, input string tag);
        exp_t e;
        logic [63:0] base;
        logic [63:0] ent;
        logic [63:0] a;
        logic [8:0]  ix;
        e.tag = tag; e.paddr = '0; e.fault = 2'd0; e.lvl = 3'd0; e.nrd = 0;
        for (int i = 0; i < 4; i++) e.adr[i] = '0;
        if (!pg) begin
            e.paddr = va;
            return e;
        end
        if (!(va[63:47] == '0 || va[63:47] == '1)) begin
            e.fault = 2'd1;
            return e;
        end
        base = root_base;
        for (int l = 4; l >= 1; l--) begin
            ix = va[12 + 9*(l-1) +: 9];
            a = base + {52'h0, ix, 3'b000};
            e.adr[e.nrd] = a;
            e.nrd++;
            ent = rd_mem(a);
            if (!ent[0]) begin
                e.fault = 2'd2; e.lvl = 3'(l);
                return e;
            end
            if ((wr && !ent[1]) || (cpl == 2'd3 && !ent[2])) begin
                e.fault = 2'd3; e.lvl = 3'(l);
                return e;
            end
            base = {12'h0, ent[51:12], 12'h0};
        end
        e.paddr = base | {52'h0, va[11:0]};
        return e;
    endfunction

    task automatic map_chain(input logic [63:0] va, input logic [63:0] frame,
                             input logic [2:0] f4, input logic [2:0] f3,
                             input logic [2:0] f2, input logic [2:0] f1);
        logic [63:0] base;
        logic [63:0] tgt;
        logic [63:0] a;
        logic [2:0]  f;
        logic [8:0]  ix;
        base = root_base;
        for (int l = 4; l >= 1; l--) begin
            ix = va[12 + 9*(l-1) +: 9];
            a = base + {52'h0, ix, 3'b000};
            if (l == 1) tgt = frame;
            else begin
                tgt = next_tbl;
                next_tbl = next_tbl + 64'h1000;
            end
            f = (l == 4) ? f4 : (l == 3) ? f3 : (l == 2) ? f2 : f1;
            mem[a] = {12'h800, tgt[51:12], 9'h0A5, f};
            base = tgt;
        end
    endtask

    task automatic send(input logic [63:0] va, input logic [1:0] cpl, input logic wr,
                        input logic pg, input string tag);
        exp_t e;
        e = model(va, cpl, wr, pg, tag);
        pg_en = pg;
        while (!req_ready) @(negedge clk);
        sb_q.push_back(e);
        req_vaddr = va; req_cpl = cpl; req_write = wr; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (!pg) chk(rsp_valid == 1'b1, {tag, " R1 response in next cycle"}, 64'(rsp_valid), 64'h1);
        while (sb_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // memory model: one read at a time, latency mem_lat >= 1
    initial begin
        logic [63:0] a;
        forever begin
            @(negedge clk);
            if (mem_rvalid) mem_rvalid = 1'b0;
            if (mem_req) begin
                a = mem_addr;
                rd_log.push_back(a);
                repeat (mem_lat) @(negedge clk);
                mem_rdata = rd_mem(a);
                mem_rvalid = 1'b1;
            end
        end
    end

    // scoreboard monitor
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (rsp_valid) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R9 unexpected response", 64'h1, 64'h0);
                end else begin
                    e = sb_q.pop_front();
                    chk(rsp_paddr == e.paddr, {e.tag, " paddr"}, rsp_paddr, e.paddr);
                    chk(rsp_fault == e.fault, {e.tag, " fault code"}, 64'(rsp_fault), 64'(e.fault));
                    chk(rsp_level == e.lvl, {e.tag, " fault level"}, 64'(rsp_level), 64'(e.lvl));
                    chk(rd_log.size() == e.nrd, {e.tag, " R10 read count"}, 64'(rd_log.size()), 64'(e.nrd));
                    for (int i = 0; i < e.nrd && i < rd_log.size(); i++)
                        chk(rd_log[i] == e.adr[i], {e.tag, " R4 read address"}, rd_log[i], e.adr[i]);
                end
                rd_log.delete();
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        map_chain(64'h0000_0012_3456_7ABC, 64'h0000_000A_BCDE_F000, 3'b111, 3'b111, 3'b111, 3'b111);
        map_chain(64'hFFFF_FFFF_8100_0123, 64'h0000_0001_0000_0000, 3'b111, 3'b111, 3'b011, 3'b111);
        map_chain(64'h0000_7F00_0000_5000, 64'h0000_0000_7777_7000, 3'b111, 3'b101, 3'b111, 3'b111);
        map_chain(64'h0000_4000_0000_0008, 64'h0000_0000_1234_5000, 3'b111, 3'b111, 3'b111, 3'b110);
        map_chain(64'h0000_2000_0000_0000, 64'h0000_0000_5555_5000, 3'b111, 3'b111, 3'b000, 3'b111);

        repeat (3) @(negedge clk);
        // R9 reset state
        chk(req_ready == 1'b1, "R9 ready in reset", 64'(req_ready), 64'h1);
        chk(rsp_valid == 1'b0, "R9 no response in reset", 64'(rsp_valid), 64'h0);
        chk(mem_req == 1'b0, "R9 no read in reset", 64'(mem_req), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R9 ready after reset", 64'(req_ready), 64'h1);

        send(64'hDEAD_BEEF_1234_5678, 2'd3, 1'b1, 1'b0, "R1 bypass");
        send(64'h0000_0012_3456_7ABC, 2'd0, 1'b0, 1'b0, "R1 bypass mapped");

        mem_lat = 1;
        send(64'h0001_0000_0000_0000, 2'd0, 1'b0, 1'b1, "R2 bit48 only");
        send(64'hFFFF_7FFF_FFFF_F000, 2'd0, 1'b0, 1'b1, "R2 upper ones bit47 clear");
        send(64'hFFFF_8000_0000_0000, 2'd0, 1'b0, 1'b1, "R2 canonical upper walked");

        send(64'h0000_0012_3456_7ABC, 2'd3, 1'b0, 1'b1, "R3 user read");
        mem_lat = 3;
        send(64'h0000_0012_3456_7ABC, 2'd0, 1'b1, 1'b1, "R3 supervisor write slow mem");
        mem_lat = 2;
        send(64'hFFFF_FFFF_8100_0123, 2'd3, 1'b0, 1'b1, "R7 user blocked level2");
        send(64'hFFFF_FFFF_8100_0123, 2'd2, 1'b1, 1'b1, "R7 cpl2 ignores user bit");
        send(64'h0000_7F00_0000_5000, 2'd0, 1'b1, 1'b1, "R6 write blocked level3");
        send(64'h0000_7F00_0000_5000, 2'd3, 1'b0, 1'b1, "R6 read ignores writable bit");
        mem_lat = 1;
        send(64'h0000_4000_0000_0008, 2'd0, 1'b0, 1'b1, "R5 not present level1");
        send(64'h0000_0800_0000_0000, 2'd0, 1'b0, 1'b1, "R5 not present level4");
        send(64'h0000_2000_0000_0000, 2'd3, 1'b1, 1'b1, "R8 not present wins");
        mem_lat = 4;
        send(64'h0000_0012_3456_7FFF, 2'd1, 1'b0, 1'b1, "R10 long latency walk");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule